// File: doc/BRIEF.md
# Floating-point register stack controller

This block holds the architectural state of an eight-entry floating-point register stack: eight 80-bit registers, one empty flag per register, a 3-bit top-of-stack pointer, a 16-bit control word and a 16-bit status word. Registers are named relative to the top pointer. Stack position n means physical entry (top + n) mod 8, and ST0 is the entry the pointer names. The block does no arithmetic. A surrounding execution unit issues one single-cycle command at a time and moves register contents through an indexed write port and an indexed read port.

The commands move the pointer, change tags, swap registers and edit the status and control words. The block also exposes the status word with the live pointer spliced in, plus two exported tag forms. The full form is a 16-bit word that classifies each register's contents. The abridged form is an 8-bit occupancy mask.

Top module: `fp_stack_ctrl`

## Requirements
- R1: Command code 1 (push) sets top to (top-1) mod 8 and marks the new top entry valid. Command code 2 (pop) marks the current top entry empty and sets top to (top+1) mod 8.
- R2: Synchronous reset and command code 7 (initialise) set top to 0, clear the stored status word, load the control word with 0x037F and mark all eight entries empty. Reset also clears every register to zero. Initialise leaves register contents unchanged.
- R3: `statusWord` equals the stored status word with bits 13:11 replaced by the top pointer. The stored copy always holds zero in bits 13:11.
- R4: Command code 8 (clear exceptions) ANDs the stored status word with 0x7F00.
- R5: Command code 3 adds 1 to top modulo 8, and command code 4 subtracts 1 modulo 8. Both clear status bits 14, 10, 9 and 8.
- R6: Command code 10 (raise) ORs `excBits` into status bits 5:0. If any raised bit has a zero in the matching bit of control[5:0], it also sets status bit 7 and bit 15.
- R7: Command code 9 (compare) replaces status bits 14, 10 and 8 according to `cmpResult`: 0 (less) gives 0x0100, 1 (equal) gives 0x4000, 2 (greater) gives 0x0000 and 3 (unordered) gives 0x4500. All other status bits are kept.
- R8: `tagWordFull` holds 2 bits per physical entry i, at bits 2i+1:2i. The code is 11 if the entry is empty. Otherwise it is 01 if exponent (bits 78:64) and mantissa (bits 63:0) are both zero, and 10 if the exponent is 0 or 0x7FFF or mantissa bit 63 is clear. Any other contents give 00.
- R9: Bit i of `tagByteAbridged` is 1 exactly when physical entry i is not empty.
- R10: Command code 5 (free) marks physical entry (top + cmdIdx) mod 8 empty and leaves the pointer unchanged.
- R11: Command code 6 (exchange) swaps the contents of ST0 and ST(cmdIdx) and leaves tags and pointer unchanged.
- R12: Command code 11 loads the control word from `loadWord`. Command code 12 sets top from loadWord[13:11] and stores loadWord with bits 13:11 cleared. Command code 13 marks entry i empty exactly when loadWord[2i+1:2i] is 11.
- R13: `regRdData` shows ST(regRdIdx) of the current state. A write stores `regWrData` into physical entry (top + regWrIdx) mod 8, using top before that cycle's command, and is ignored in a cycle with an accepted exchange. A command is ignored when `cmdValid` is low, and during reset. Code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command strobe |
| cmd | input | 4 | Command code |
| cmdIdx | input | 3 | Stack position for free and exchange |
| cmpResult | input | 2 | Comparison outcome for compare |
| excBits | input | 6 | Exception bits for raise |
| loadWord | input | 16 | Operand for the three load commands |
| regWrEn | input | 1 | Register write enable |
| regWrIdx | input | 3 | Stack position written |
| regWrData | input | 80 | Register write data |
| regRdIdx | input | 3 | Stack position read |
| regRdData | output | 80 | Register read data |
| ctrlWord | output | 16 | Control word |
| statusWord | output | 16 | Status word with top pointer in bits 13:11 |
| tagWordFull | output | 16 | Two-bit classification per entry |
| tagByteAbridged | output | 8 | Occupancy mask |
| topPtr | output | 3 | Top-of-stack pointer |

## Verification
Every command and register write changes state on the clock edge where it is applied. `topPtr`, the status word, the control word and both tag forms are registered or decoded straight from state, so all of them are due one edge after the stimulus. `regRdData` follows `regRdIdx` combinationally from that same updated state. The bench drives inputs just after a falling edge, advances its behavioural model on the next rising edge, and compares every output at the following falling edge. Each comparison therefore lands exactly one edge after its stimulus and is never mid-update.

// File: rtl/fp_stack_pkg.sv
package fp_stack_pkg;
  localparam int FP_PTR_W = 3;
  localparam int FP_DEPTH = 1 << FP_PTR_W;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_PUSH  = 4'd1,
    CMD_POP   = 4'd2,
    CMD_INC   = 4'd3,
    CMD_DEC   = 4'd4,
    CMD_FREE  = 4'd5,
    CMD_XCHG  = 4'd6,
    CMD_INIT  = 4'd7,
    CMD_CLEX  = 4'd8,
    CMD_CMP   = 4'd9,
    CMD_RAISE = 4'd10,
    CMD_LDCW  = 4'd11,
    CMD_LDSW  = 4'd12,
    CMD_LDTW  = 4'd13
  } fpCmd_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic inc;
    logic dec;
    logic free;
    logic xchg;
    logic init;
    logic clex;
    logic cmp;
    logic raise;
    logic ldcw;
    logic ldsw;
    logic ldtw;
  } fpStrobe_t;
endpackage

// File: rtl/fp_stack_decode.sv
module fp_stack_decode
  import fp_stack_pkg::*;
(
  input  logic      rst,
  input  logic      cmdValid,
  input  logic [3:0] cmd,
  output fpStrobe_t stb
);
  always_comb begin
    stb = '0;
    if (cmdValid && !rst) begin
      case (cmd)
        CMD_PUSH:  stb.push  = 1'b1;
        CMD_POP:   stb.pop   = 1'b1;
        CMD_INC:   stb.inc   = 1'b1;
        CMD_DEC:   stb.dec   = 1'b1;
        CMD_FREE:  stb.free  = 1'b1;
        CMD_XCHG:  stb.xchg  = 1'b1;
        CMD_INIT:  stb.init  = 1'b1;
        CMD_CLEX:  stb.clex  = 1'b1;
        CMD_CMP:   stb.cmp   = 1'b1;
        CMD_RAISE: stb.raise = 1'b1;
        CMD_LDCW:  stb.ldcw  = 1'b1;
        CMD_LDSW:  stb.ldsw  = 1'b1;
        CMD_LDTW:  stb.ldtw  = 1'b1;
        default:   stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/fp_stack_dp.sv
module fp_stack_dp
  import fp_stack_pkg::*;
#(
  parameter int REG_W = 80,
  parameter int EXP_W = 15,
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fpStrobe_t             stb,
  input  logic [FP_PTR_W-1:0]   cmdIdx,
  input  logic [1:0]            cmpResult,
  input  logic [5:0]            excBits,
  input  logic [WORD_W-1:0]     loadWord,
  input  logic                  regWrEn,
  input  logic [FP_PTR_W-1:0]   regWrIdx,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [FP_PTR_W-1:0]   regRdIdx,
  output logic [REG_W-1:0]      regRdData,
  output logic [WORD_W-1:0]     ctrlWord,
  output logic [WORD_W-1:0]     statusWord,
  output logic [2*FP_DEPTH-1:0] tagWordFull,
  output logic [FP_DEPTH-1:0]   tagByteAbridged,
  output logic [FP_PTR_W-1:0]   topPtr
);
  localparam int MAN_W = REG_W - 1 - EXP_W;
  localparam logic [WORD_W-1:0] INIT_CW   = 16'h037F;
  localparam logic [WORD_W-1:0] KEEP_CLEX = 16'h7F00;
  localparam logic [WORD_W-1:0] CC_MOVE   = 16'h4700;
  localparam logic [WORD_W-1:0] CC_CMP    = 16'h4500;
  localparam logic [WORD_W-1:0] TOP_FIELD = 16'h3800;

  logic [REG_W-1:0]    regs [FP_DEPTH];
  logic [FP_DEPTH-1:0] emptyTag;
  logic [FP_PTR_W-1:0] top;
  logic [WORD_W-1:0]   cw;
  logic [WORD_W-1:0]   sw;

  logic [FP_PTR_W-1:0] physN, physW, topDn, topUp;
  logic [WORD_W-1:0]   cmpBits;
  logic                unmasked;

  assign physN    = top + cmdIdx;
  assign physW    = top + regWrIdx;
  assign topDn    = top - 1'b1;
  assign topUp    = top + 1'b1;
  assign unmasked = |(excBits & ~cw[5:0]);

  always_comb begin
    case (cmpResult)
      2'd0:    cmpBits = 16'h0100;
      2'd1:    cmpBits = 16'h4000;
      2'd2:    cmpBits = 16'h0000;
      default: cmpBits = 16'h4500;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top      <= '0;
      cw       <= INIT_CW;
      sw       <= '0;
      emptyTag <= '1;
      for (int i = 0; i < FP_DEPTH; i++) regs[i] <= '0;
    end else begin
      if (stb.xchg) begin
        regs[top]   <= regs[physN];
        regs[physN] <= regs[top];
      end else if (regWrEn) begin
        regs[physW] <= regWrData;
      end

      if (stb.push) begin
        top             <= topDn;
        emptyTag[topDn] <= 1'b0;
      end else if (stb.pop) begin
        emptyTag[top] <= 1'b1;
        top           <= topUp;
      end else if (stb.inc) begin
        top <= topUp;
        sw  <= sw & ~CC_MOVE;
      end else if (stb.dec) begin
        top <= topDn;
        sw  <= sw & ~CC_MOVE;
      end else if (stb.free) begin
        emptyTag[physN] <= 1'b1;
      end else if (stb.init) begin
        top      <= '0;
        cw       <= INIT_CW;
        sw       <= '0;
        emptyTag <= '1;
      end else if (stb.clex) begin
        sw <= sw & KEEP_CLEX;
      end else if (stb.cmp) begin
        sw <= (sw & ~CC_CMP) | cmpBits;
      end else if (stb.raise) begin
        sw <= sw | {10'd0, excBits} | (unmasked ? 16'h8080 : 16'h0000);
      end else if (stb.ldcw) begin
        cw <= loadWord;
      end else if (stb.ldsw) begin
        top <= loadWord[13:11];
        sw  <= loadWord & ~TOP_FIELD;
      end else if (stb.ldtw) begin
        for (int i = 0; i < FP_DEPTH; i++)
          emptyTag[i] <= (loadWord[2*i+:2] == 2'b11);
      end
    end
  end

  for (genvar g = 0; g < FP_DEPTH; g++) begin : gTag
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
    assign expo = regs[g][REG_W-2 -: EXP_W];
    assign mant = regs[g][MAN_W-1:0];
    always_comb begin
      if (emptyTag[g])                                tagWordFull[2*g+:2] = 2'b11;
      else if (expo == '0 && mant == '0)              tagWordFull[2*g+:2] = 2'b01;
      else if (expo == '0 || expo == '1 || !mant[MAN_W-1])
                                                      tagWordFull[2*g+:2] = 2'b10;
      else                                            tagWordFull[2*g+:2] = 2'b00;
    end
    assign tagByteAbridged[g] = ~emptyTag[g];
  end

  assign regRdData  = regs[top + regRdIdx];
  assign ctrlWord   = cw;
  assign statusWord = {sw[15:14], top, sw[10:0]};
  assign topPtr     = top;
endmodule

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl
  import fp_stack_pkg::*;
#(
  parameter int REG_W = 80,
  parameter int EXP_W = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmdValid,
  input  logic [3:0]            cmd,
  input  logic [FP_PTR_W-1:0]   cmdIdx,
  input  logic [1:0]            cmpResult,
  input  logic [5:0]            excBits,
  input  logic [15:0]           loadWord,
  input  logic                  regWrEn,
  input  logic [FP_PTR_W-1:0]   regWrIdx,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [FP_PTR_W-1:0]   regRdIdx,
  output logic [REG_W-1:0]      regRdData,
  output logic [15:0]           ctrlWord,
  output logic [15:0]           statusWord,
  output logic [2*FP_DEPTH-1:0] tagWordFull,
  output logic [FP_DEPTH-1:0]   tagByteAbridged,
  output logic [FP_PTR_W-1:0]   topPtr
);
  fpStrobe_t stb;

  fp_stack_decode u_decode (
    .rst(rst), .cmdValid(cmdValid), .cmd(cmd), .stb(stb)
  );

  fp_stack_dp #(.REG_W(REG_W), .EXP_W(EXP_W), .WORD_W(16)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cmdIdx(cmdIdx), .cmpResult(cmpResult),
    .excBits(excBits), .loadWord(loadWord), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData), .regRdIdx(regRdIdx),
    .regRdData(regRdData), .ctrlWord(ctrlWord), .statusWord(statusWord),
    .tagWordFull(tagWordFull), .tagByteAbridged(tagByteAbridged),
    .topPtr(topPtr)
  );
endmodule

// File: rtl/fp_stack_chk.sv
module fp_stack_chk
  import fp_stack_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cmdValid,
  input logic [3:0]          cmd,
  input logic [FP_PTR_W-1:0] cmdIdx,
  input logic [1:0]          cmpResult,
  input logic [5:0]          excBits,
  input logic [15:0]         ctrlWord,
  input logic [15:0]         statusWord,
  input logic [FP_DEPTH-1:0] tagByteAbridged,
  input logic [FP_PTR_W-1:0] topPtr
);
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_PUSH) |=> topPtr == $past(topPtr) - 3'd1); // R1
  AST_POP_TOP: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_POP) |=> topPtr == $past(topPtr) + 3'd1); // R1
  AST_INIT_STATE: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_INIT) |=> (topPtr == 3'd0 && statusWord == 16'h0000
      && ctrlWord == 16'h037F && tagByteAbridged == 8'h00)); // R2
  AST_CLEX_BITS: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_CLEX) |=> (statusWord[7:0] == 8'h00 && !statusWord[15]
      && $stable(topPtr))); // R4
  AST_MOVE_CC: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && (cmd == CMD_INC || cmd == CMD_DEC)) |=>
      (statusWord[14] == 1'b0 && statusWord[10:8] == 3'b000)); // R5
  AST_RAISE_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_RAISE && |(excBits & ~ctrlWord[5:0])) |=>
      (statusWord[7] && statusWord[15])); // R6
  AST_CMP_UNORD: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_CMP && cmpResult == 2'd3) |=>
      (statusWord[14] && statusWord[10] && statusWord[8])); // R7
  AST_FREE_STILL: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmd == CMD_FREE) |=> (topPtr == $past(topPtr)
      && tagByteAbridged[$past(topPtr + cmdIdx)] == 1'b0)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid) |=> ($stable(topPtr) && $stable(ctrlWord) && $stable(statusWord)
      && $stable(tagByteAbridged))); // R13
endmodule

bind fp_stack_ctrl fp_stack_chk u_chk (.*);

// File: tb/fp_stack_ctrl_tb.sv
module fp_stack_ctrl_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmd = 4'd0;
  logic [2:0]  cmdIdx = 3'd0;
  logic [1:0]  cmpResult = 2'd0;
  logic [5:0]  excBits = 6'd0;
  logic [15:0] loadWord = 16'd0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrIdx = 3'd0;
  logic [79:0] regWrData = 80'd0;
  logic [2:0]  regRdIdx = 3'd0;
  logic [79:0] regRdData;
  logic [15:0] ctrlWord, statusWord, tagWordFull;
  logic [7:0]  tagByteAbridged;
  logic [2:0]  topPtr;

  fp_stack_ctrl u_dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmd(cmd), .cmdIdx(cmdIdx),
    .cmpResult(cmpResult), .excBits(excBits), .loadWord(loadWord),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .regRdIdx(regRdIdx), .regRdData(regRdData), .ctrlWord(ctrlWord),
    .statusWord(statusWord), .tagWordFull(tagWordFull),
    .tagByteAbridged(tagByteAbridged), .topPtr(topPtr)
  );

  // behavioural reference state
  int          mTop;
  logic [15:0] mCw, mSw;
  bit          mEmpty [8];
  logic [79:0] mRegs [8];

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string phase = "R2";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mTop = 0; mCw = 16'h037F; mSw = 16'h0000;
      for (int i = 0; i < 8; i++) begin mEmpty[i] = 1'b1; mRegs[i] = 80'd0; end
    end else begin
      automatic int pn = (mTop + int'(cmdIdx)) % 8;
      automatic int pw = (mTop + int'(regWrIdx)) % 8;
      automatic bit isX = cmdValid && cmd == 4'd6;
      if (regWrEn && !isX) mRegs[pw] = regWrData;
      if (cmdValid) begin
        case (cmd)
          4'd1: begin mTop = (mTop + 7) % 8; mEmpty[mTop] = 1'b0; end
          4'd2: begin mEmpty[mTop] = 1'b1; mTop = (mTop + 1) % 8; end
          4'd3: begin mTop = (mTop + 1) % 8; mSw = mSw & 16'hB8FF; end
          4'd4: begin mTop = (mTop + 7) % 8; mSw = mSw & 16'hB8FF; end
          4'd5: mEmpty[pn] = 1'b1;
          4'd6: begin
            automatic logic [79:0] t = mRegs[mTop];
            mRegs[mTop] = mRegs[pn]; mRegs[pn] = t;
          end
          4'd7: begin
            mTop = 0; mCw = 16'h037F; mSw = 16'h0000;
            for (int i = 0; i < 8; i++) mEmpty[i] = 1'b1;
          end
          4'd8: mSw = mSw & 16'h7F00;
          4'd9: begin
            mSw = mSw & 16'hBAFF;
            case (cmpResult)
              2'd0: mSw = mSw | 16'h0100;
              2'd1: mSw = mSw | 16'h4000;
              2'd2: mSw = mSw;
              default: mSw = mSw | 16'h4500;
            endcase
          end
          4'd10: begin
            mSw = mSw | {10'd0, excBits};
            if ((excBits & ~mCw[5:0]) != 6'd0) mSw = mSw | 16'h8080;
          end
          4'd11: mCw = loadWord;
          4'd12: begin mTop = int'(loadWord[13:11]); mSw = loadWord & 16'hC7FF; end
          4'd13: for (int i = 0; i < 8; i++) mEmpty[i] = (loadWord[2*i+:2] == 2'b11);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [1:0] classOf(int i);
    logic [14:0] e;
    logic [63:0] m;
    e = mRegs[i][78:64];
    m = mRegs[i][63:0];
    if (mEmpty[i]) return 2'b11;
    if (e == 15'd0 && m == 64'd0) return 2'b01;
    if (e == 15'd0 || e == 15'h7FFF || !m[63]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string req, string what, logic [79:0] act, logic [79:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [15:0] tf, sw;
    logic [7:0]  ab;
    for (int i = 0; i < 8; i++) begin
      tf[2*i+:2] = classOf(i);
      ab[i] = !mEmpty[i];
    end
    sw = {mSw[15:14], 3'(mTop), mSw[10:0]};
    check({phase, "/R1"}, "topPtr", 80'(topPtr), 80'(mTop));
    check({phase, "/R2"}, "ctrlWord", 80'(ctrlWord), 80'(mCw));
    check({phase, "/R3"}, "statusWord", 80'(statusWord), 80'(sw));
    check({phase, "/R8"}, "tagWordFull", 80'(tagWordFull), 80'(tf));
    check({phase, "/R9"}, "tagByteAbridged", 80'(tagByteAbridged), 80'(ab));
    check({phase, "/R13"}, "regRdData", regRdData, mRegs[(mTop + int'(regRdIdx)) % 8]);
  endtask

  task automatic step(bit v, logic [3:0] c, logic [2:0] n, logic [1:0] cr,
                      logic [5:0] ex, logic [15:0] lw, bit we, logic [2:0] wi,
                      logic [79:0] wd, logic [2:0] ri);
    cmdValid = v; cmd = c; cmdIdx = n; cmpResult = cr; excBits = ex;
    loadWord = lw; regWrEn = we; regWrIdx = wi; regWrData = wd; regRdIdx = ri;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic cmdOnly(logic [3:0] c, logic [2:0] n, logic [2:0] ri);
    step(1'b1, c, n, 2'd0, 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, ri);
  endtask

  task automatic wr(logic [2:0] wi, logic [79:0] wd, logic [2:0] ri);
    step(1'b0, 4'd0, 3'd0, 2'd0, 6'd0, 16'd0, 1'b1, wi, wd, ri);
  endtask

  logic [79:0] pat [6];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    pat[0] = 80'h3FFF_8000000000000000; // normal -> 00
    pat[1] = 80'h0000_0000000000000000; // zero -> 01
    pat[2] = 80'h0000_0000000000000001; // denormal -> 10
    pat[3] = 80'h7FFF_8000000000000000; // infinity -> 10
    pat[4] = 80'h0001_4000000000000000; // bit 63 clear -> 10
    pat[5] = 80'hC000_C000000000000000; // negative normal -> 00

    phase = "R2";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    compareAll();

    phase = "R1";
    for (int k = 0; k < 6; k++) begin
      cmdOnly(4'd1, 3'd0, 3'd0);
      wr(3'd0, pat[k], 3'(k));
    end
    cmdOnly(4'd1, 3'd0, 3'd1);
    cmdOnly(4'd2, 3'd0, 3'd2);
    cmdOnly(4'd2, 3'd0, 3'd0);

    phase = "R13";
    step(1'b1, 4'd1, 3'd0, 2'd0, 6'd0, 16'd0, 1'b1, 3'd1, 80'h1234_5555AAAA5555AAAA, 3'd2);
    wr(3'd7, 80'h4001_F0F0F0F0F0F0F0F0, 3'd7);
    step(1'b0, 4'd1, 3'd0, 2'd0, 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, 3'd0);
    step(1'b0, 4'd7, 3'd0, 2'd0, 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, 3'd3);
    step(1'b1, 4'd0, 3'd0, 2'd0, 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, 3'd4);

    phase = "R11";
    cmdOnly(4'd6, 3'd3, 3'd0);
    cmdOnly(4'd6, 3'd3, 3'd3);
    step(1'b1, 4'd6, 3'd1, 2'd0, 6'd0, 16'd0, 1'b1, 3'd1, 80'hDEAD_BEEF00000000CAFE, 3'd1);
    cmdOnly(4'd6, 3'd0, 3'd0);

    phase = "R10";
    cmdOnly(4'd5, 3'd2, 3'd2);
    cmdOnly(4'd5, 3'd7, 3'd0);

    phase = "R7";
    for (int r = 0; r < 4; r++)
      step(1'b1, 4'd9, 3'd0, 2'(r), 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, 3'd0);

    phase = "R5";
    cmdOnly(4'd4, 3'd0, 3'd0);
    step(1'b1, 4'd9, 3'd0, 2'd3, 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, 3'd0);
    cmdOnly(4'd3, 3'd0, 3'd1);
    for (int k = 0; k < 9; k++) cmdOnly(4'd3, 3'd0, 3'(k));
    cmdOnly(4'd4, 3'd0, 3'd0);

    phase = "R6";
    step(1'b1, 4'd10, 3'd0, 2'd0, 6'h3F, 16'd0, 1'b0, 3'd0, 80'd0, 3'd0);
    step(1'b1, 4'd11, 3'd0, 2'd0, 6'd0, 16'h033B, 1'b0, 3'd0, 80'd0, 3'd0);
    step(1'b1, 4'd10, 3'd0, 2'd0, 6'h04, 16'd0, 1'b0, 3'd0, 80'd0, 3'd0);

    phase = "R4";
    step(1'b1, 4'd9, 3'd0, 2'd3, 6'd0, 16'd0, 1'b0, 3'd0, 80'd0, 3'd0);
    cmdOnly(4'd8, 3'd0, 3'd0);

    phase = "R12";
    step(1'b1, 4'd12, 3'd0, 2'd0, 6'd0, 16'hFFFF, 1'b0, 3'd0, 80'd0, 3'd0);
    step(1'b1, 4'd12, 3'd0, 2'd0, 6'd0, 16'h2A55, 1'b0, 3'd0, 80'd0, 3'd2);
    step(1'b1, 4'd13, 3'd0, 2'd0, 6'd0, 16'h1BE4, 1'b0, 3'd0, 80'd0, 3'd0);
    step(1'b1, 4'd13, 3'd0, 2'd0, 6'd0, 16'hC003, 1'b0, 3'd0, 80'd0, 3'd0);
    step(1'b1, 4'd11, 3'd0, 2'd0, 6'd0, 16'hA5C3, 1'b0, 3'd0, 80'd0, 3'd0);

    phase = "R2";
    cmdOnly(4'd7, 3'd0, 3'd5);
    rst = 1'b1;
    cmdOnly(4'd1, 3'd0, 3'd0);
    cmdOnly(4'd10, 3'd0, 3'd0);
    rst = 1'b0;
    cmdOnly(4'd0, 3'd0, 3'd0);

    phase = "RND";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], 4'(lfsr[4:1] % 14), lfsr[7:5], lfsr[9:8], lfsr[15:10],
           {lfsr[31:16]}, lfsr[3], lfsr[18:16],
           {lfsr[0] ? pat[lfsr[2:1]] : {lfsr[15:0], lfsr, lfsr}}, lfsr[22:20]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule